// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block forms data-memory word addresses for a signal-processing data path. It keeps eight 16-bit pointers, each with a 7-bit page register. On every access it sends out a 23-bit word address built from the selected pointer's value before the update. On the same clock edge it writes back the modified pointer. The upper 7 address bits are the page, joined to the pointer bits and never added to them. The data space is therefore 128 pages of 64K words.

Each pointer has its own enable bit for circular mode. When that bit is set and the pointer's size register is non-zero, the pointer holds an offset into a ring buffer, and the address is the buffer start plus that offset. Start registers are shared by pairs of pointers and size registers by groups of four. Updates that leave the range 0 to size-1 are folded back into it.

Configuration uses a simple word-wide write and read port with a small register map. Instruction decode, the memory itself and arbitration between parallel accesses belong to neighbouring blocks.

Top module: `circbuf_agu`

## Requirements
- R1: After reset every pointer, page, start, size and enable register reads zero, and the emitted address is zero.
- R2: The address is always {page[sel], value} formed from the selected pointer's value before the update. With acc_en low, or with acc_mode 0 (hold), no pointer changes.
- R3: acc_mode 1 adds and acc_mode 2 subtracts a step to or from the selected pointer. The step is 2 when acc_wide is 1 and 1 otherwise. In linear mode the result wraps modulo 2^16 and the page is never changed.
- R4: acc_mode 3 adds the value of pointer 0 to the selected pointer. When pointer 0 itself is selected, it doubles.
- R5: Bit i of the enable register (cfg address 22) turns on circular mode for pointer i. The low 16 address bits are then (start + pointer) mod 2^16.
- R6: Pointer i uses start register i/2 (cfg addresses 16 to 19) and size register i/4 (cfg addresses 20 and 21).
- R7: In circular mode the raw update result is corrected once. A negative result has the size added, and a result greater than or equal to the size has the size subtracted.
- R8: A size register holding zero turns off circular behaviour for its four pointers, whatever their enable bits hold.
- R9: When a configuration write and an access update hit the same pointer in one cycle, the written value is the one kept.
- R10: The register map is: addresses 0 to 7 are pointers, 8 to 15 are pages (low 7 bits), 16 to 19 are starts, 20 and 21 are sizes, and 22 holds the enables (low 8 bits). Reads come back combinationally on cfg_rdata. Other addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Access this cycle |
| acc_sel | input | 3 | Pointer selected for the access |
| acc_mode | input | 2 | Update kind: 0 hold, 1 increment, 2 decrement, 3 indexed |
| acc_wide | input | 1 | Operand is 32 bits (step 2) |
| acc_addr | output | 23 | Word address from the pre-update pointer |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |

## Verification
A corrupted pointer, page, start or size register shows up on acc_addr as soon as that pointer is selected. Every register can also be read back on cfg_rdata in the cycle it is addressed. A wrong post-modify value appears on the address at the next access through the same pointer, one clock after the faulty update. A fault in the wrap or sharing logic shows up only when the update crosses a buffer end, or when a neighbour that shares a register is selected. For this reason the stimulus drives pointers across both buffer ends and switches between pointers that share a start or size register.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_INC  = 2'd1,
        UPD_DEC  = 2'd2,
        UPD_IDX  = 2'd3
    } upd_e;
endpackage

// File: rtl/agu_next.sv
module agu_next
    import agu_pkg::*;
#(
    parameter int PW = 16
) (
    input  upd_e            mode,
    input  logic            wide,
    input  logic [PW-1:0]   cur,
    input  logic [PW-1:0]   idx,
    input  logic            circ,
    input  logic [PW-1:0]   size,
    output logic [PW-1:0]   nxt
);
    localparam int XW = PW + 2;

    logic signed [XW-1:0] delta;
    logic signed [XW-1:0] raw;
    logic signed [XW-1:0] sz;
    logic signed [XW-1:0] fixed;

    always_comb begin
        unique case (mode)
            UPD_INC: delta = wide ? XW'(2) : XW'(1);
            UPD_DEC: delta = wide ? XW'(-2) : XW'(-1);
            UPD_IDX: delta = signed'({2'b00, idx});
            default: delta = '0;
        endcase
        sz  = signed'({2'b00, size});
        raw = signed'({2'b00, cur}) + delta;
        if (circ && raw < 0)        fixed = raw + sz;
        else if (circ && raw >= sz) fixed = raw - sz;
        else                        fixed = raw;
        nxt = fixed[PW-1:0];
    end
endmodule

// File: rtl/agu_form.sv
module agu_form #(
    parameter int PW  = 16,
    parameter int PGW = 7
) (
    input  logic [PGW-1:0]    page,
    input  logic [PW-1:0]     ptr,
    input  logic [PW-1:0]     start,
    input  logic              circ,
    output logic [PGW+PW-1:0] addr
);
    logic [PW-1:0] low;
    always_comb begin
        low  = circ ? PW'(start + ptr) : ptr;
        addr = {page, low};
    end
endmodule

// File: rtl/circbuf_agu.sv
module circbuf_agu
    import agu_pkg::*;
#(
    parameter int NPTR = 8,
    parameter int PW   = 16,
    parameter int PGW  = 7,
    parameter int CAW  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_en,
    input  logic [$clog2(NPTR)-1:0] acc_sel,
    input  logic [1:0]              acc_mode,
    input  logic                    acc_wide,
    output logic [PGW+PW-1:0]       acc_addr,
    input  logic                    cfg_we,
    input  logic [CAW-1:0]          cfg_addr,
    input  logic [PW-1:0]           cfg_wdata,
    output logic [PW-1:0]           cfg_rdata
);
    localparam int SW      = $clog2(NPTR);
    localparam int NST     = NPTR / 2;
    localparam int NSZ     = NPTR / 4;
    localparam int STW     = $clog2(NST);
    localparam int SZW     = (NSZ > 1) ? $clog2(NSZ) : 1;
    localparam int A_PAGE  = NPTR;
    localparam int A_START = 2 * NPTR;
    localparam int A_SIZE  = A_START + NST;
    localparam int A_EN    = A_SIZE + NSZ;

    typedef struct {
        logic [PW-1:0]   ptr   [NPTR];
        logic [PGW-1:0]  page  [NPTR];
        logic [PW-1:0]   start [NST];
        logic [PW-1:0]   size  [NSZ];
        logic [NPTR-1:0] circ_en;
    } agu_st_t;

    agu_st_t s_d, s_q;

    // per-pointer view of the shared registers
    logic [PW-1:0]   start_of [NPTR];
    logic [PW-1:0]   size_of  [NPTR];
    logic [NPTR-1:0] circ_of;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        assign start_of[g] = s_q.start[g / 2];
        assign size_of[g]  = s_q.size[g / 4];
        assign circ_of[g]  = s_q.circ_en[g] && (s_q.size[g / 4] != '0);
    end

    upd_e          mode_w;
    logic [PW-1:0] nxt_ptr;
    assign mode_w = upd_e'(acc_mode);

    agu_next #(.PW(PW)) u_next (
        .mode (mode_w),
        .wide (acc_wide),
        .cur  (s_q.ptr[acc_sel]),
        .idx  (s_q.ptr[0]),
        .circ (circ_of[acc_sel]),
        .size (size_of[acc_sel]),
        .nxt  (nxt_ptr)
    );

    agu_form #(.PW(PW), .PGW(PGW)) u_form (
        .page  (s_q.page[acc_sel]),
        .ptr   (s_q.ptr[acc_sel]),
        .start (start_of[acc_sel]),
        .circ  (circ_of[acc_sel]),
        .addr  (acc_addr)
    );

    logic [CAW-1:0] rel_st, rel_sz;
    assign rel_st = cfg_addr - CAW'(A_START);
    assign rel_sz = cfg_addr - CAW'(A_SIZE);

    // next state: access update first, configuration write overrides
    always_comb begin
        s_d = s_q;
        if (acc_en && mode_w != UPD_HOLD) s_d.ptr[acc_sel] = nxt_ptr;
        if (cfg_we) begin
            if (cfg_addr < CAW'(A_PAGE))
                s_d.ptr[cfg_addr[SW-1:0]] = cfg_wdata;
            else if (cfg_addr < CAW'(A_START))
                s_d.page[cfg_addr[SW-1:0]] = cfg_wdata[PGW-1:0];
            else if (cfg_addr < CAW'(A_SIZE))
                s_d.start[rel_st[STW-1:0]] = cfg_wdata;
            else if (cfg_addr < CAW'(A_EN))
                s_d.size[rel_sz[SZW-1:0]] = cfg_wdata;
            else if (cfg_addr == CAW'(A_EN))
                s_d.circ_en = cfg_wdata[NPTR-1:0];
        end
    end

    always_comb begin
        if (cfg_addr < CAW'(A_PAGE))
            cfg_rdata = s_q.ptr[cfg_addr[SW-1:0]];
        else if (cfg_addr < CAW'(A_START))
            cfg_rdata = PW'(s_q.page[cfg_addr[SW-1:0]]);
        else if (cfg_addr < CAW'(A_SIZE))
            cfg_rdata = s_q.start[rel_st[STW-1:0]];
        else if (cfg_addr < CAW'(A_EN))
            cfg_rdata = s_q.size[rel_sz[SZW-1:0]];
        else if (cfg_addr == CAW'(A_EN))
            cfg_rdata = PW'(s_q.circ_en);
        else
            cfg_rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPTR; i++) begin
                s_q.ptr[i]  <= '0;
                s_q.page[i] <= '0;
            end
            for (int i = 0; i < NST; i++) s_q.start[i] <= '0;
            for (int i = 0; i < NSZ; i++) s_q.size[i]  <= '0;
            s_q.circ_en <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // linear increment moves the pointer by the operand step
    assert_lin_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && mode_w == UPD_INC && !circ_of[acc_sel] && !cfg_we)
        |=> s_q.ptr[$past(acc_sel)] ==
            PW'($past(s_q.ptr[acc_sel]) + ($past(acc_wide) ? 2 : 1)));

    // an in-range circular offset stays in range after a step
    assert_circ_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && circ_of[acc_sel] && (mode_w == UPD_INC || mode_w == UPD_DEC)
         && s_q.ptr[acc_sel] < size_of[acc_sel] && size_of[acc_sel] >= PW'(2) && !cfg_we)
        |=> s_q.ptr[$past(acc_sel)] < $past(size_of[acc_sel]));

    // write data wins over a same-cycle update
    assert_cfg_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr < CAW'(A_PAGE))
        |=> s_q.ptr[$past(cfg_addr[SW-1:0])] == $past(cfg_wdata));

    // no access and no write: the address of an unchanged selection holds
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((!acc_en || mode_w == UPD_HOLD) && !cfg_we)
        |=> (!$stable(acc_sel) || $stable(acc_addr)));
endmodule

// File: tb/sim_circbuf_agu.sv
module sim_circbuf_agu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic [2:0]  acc_sel = '0;
    logic [1:0]  acc_mode = '0;
    logic        acc_wide = 1'b0;
    logic [22:0] acc_addr;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;

    always #10 clk = ~clk;

    circbuf_agu u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_sel(acc_sel),
        .acc_mode(acc_mode), .acc_wide(acc_wide), .acc_addr(acc_addr),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // reference model state
    int mp[8];
    int mpg[8];
    int mst[4];
    int msz[2];
    int men;

    function automatic bit m_circ(int i);
        return ((men >> i) & 1) == 1 && msz[i / 4] != 0;
    endfunction

    function automatic int m_addr(int i);
        int low;
        low = m_circ(i) ? ((mst[i / 2] + mp[i]) & 16'hFFFF) : mp[i];
        return (mpg[i] << 16) | low;
    endfunction

    function automatic int m_read(int a);
        if (a < 8)  return mp[a];
        if (a < 16) return mpg[a - 8];
        if (a < 20) return mst[a - 16];
        if (a < 22) return msz[a - 20];
        if (a == 22) return men;
        return 0;
    endfunction

    function automatic int m_next(int i, int mode, bit wide);
        int s;
        int st;
        st = wide ? 2 : 1;
        case (mode)
            1: s = mp[i] + st;
            2: s = mp[i] - st;
            3: s = mp[i] + mp[0];
            default: s = mp[i];
        endcase
        if (m_circ(i)) begin
            if (s < 0) s = s + msz[i / 4];
            else if (s >= msz[i / 4]) s = s - msz[i / 4];
        end
        return s & 16'hFFFF;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin mp[i] = 0; mpg[i] = 0; end
            for (int i = 0; i < 4; i++) mst[i] = 0;
            for (int i = 0; i < 2; i++) msz[i] = 0;
            men = 0;
        end else begin
            if (acc_en && acc_mode != 0)
                mp[acc_sel] = m_next(int'(acc_sel), int'(acc_mode), acc_wide);
            if (cfg_we) begin
                int a;
                a = int'(cfg_addr);
                if (a < 8) mp[a] = int'(cfg_wdata);
                else if (a < 16) mpg[a - 8] = int'(cfg_wdata) & 8'h7F;
                else if (a < 20) mst[a - 16] = int'(cfg_wdata);
                else if (a < 22) msz[a - 20] = int'(cfg_wdata);
                else if (a == 22) men = int'(cfg_wdata) & 8'hFF;
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        int ea;
        int er;
        ea = (!rst_n) ? 0 : m_addr(int'(acc_sel));
        er = (!rst_n) ? 0 : m_read(int'(cfg_addr));
        n_cmp++;
        if (int'(acc_addr) != ea) begin
            n_bad++;
            $display("FAIL %s acc_addr actual=%h expected=%h", cur_req, acc_addr, ea);
        end
        n_cmp++;
        if (int'(cfg_rdata) != er) begin
            n_bad++;
            $display("FAIL %s cfg_rdata actual=%h expected=%h", cur_req, cfg_rdata, er);
        end
    end

    task automatic acc(input int sel, input int mode, input bit wide);
        @(posedge clk); #2;
        acc_en = 1'b1; acc_sel = 3'(sel); acc_mode = 2'(mode); acc_wide = wide;
        cfg_we = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        @(posedge clk); #2;
        acc_en = 1'b0; cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
    endtask

    task automatic rd(input int a);
        @(posedge clk); #2;
        acc_en = 1'b0; cfg_we = 1'b0; cfg_addr = 5'(a);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        for (int a = 0; a < 32; a++) rd(a);

        // R10: register map write and readback, unused addresses
        cur_req = "R10";
        for (int a = 0; a < 32; a++) begin
            wr(a, 16'hA5C3 ^ (a * 16'h0111));
            rd(a);
        end
        for (int a = 0; a < 23; a++) wr(a, 0);

        // R2: linear address with page concatenation, hold mode
        cur_req = "R2";
        for (int i = 0; i < 8; i++) begin
            wr(i, 16'h1000 * i + 16'h00F0);
            wr(8 + i, 16'h7F - i);
        end
        for (int i = 0; i < 8; i++) acc(i, 0, 0);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #2; acc_en = 1'b0; acc_sel = 3'(i);
        end

        // R3: increment and decrement, step by width, 16-bit wrap
        cur_req = "R3";
        wr(3, 16'hFFFE);
        acc(3, 1, 0); acc(3, 1, 1); acc(3, 1, 1);
        acc(3, 2, 1); acc(3, 2, 0); acc(3, 2, 0); acc(3, 2, 1);
        wr(5, 0);
        acc(5, 2, 0); acc(5, 2, 1); acc(5, 0, 0);

        // R4: indexed update, including pointer 0 itself
        cur_req = "R4";
        wr(0, 16'h0013);
        acc(6, 3, 0); acc(6, 3, 1); acc(0, 3, 0); acc(2, 3, 0); acc(2, 0, 0);

        // R5 and R6: circular enable per pointer, shared start/size
        cur_req = "R5";
        wr(16, 16'h0400); wr(17, 16'h0800); wr(18, 16'hFFF0); wr(19, 16'h2000);
        wr(20, 10); wr(21, 6);
        wr(22, 8'b0101_0101);
        for (int i = 0; i < 8; i++) wr(i, i % 4);
        for (int i = 0; i < 8; i++) acc(i, 0, 0);
        cur_req = "R6";
        for (int i = 0; i < 8; i++) acc(i, 1, 0);
        for (int i = 0; i < 8; i++) acc(i, 0, 0);
        wr(22, 8'hFF);
        for (int i = 0; i < 8; i++) acc(i, 0, 0);

        // R7: wrap past both ends, wide steps and indexed wrap
        cur_req = "R7";
        wr(1, 8);
        acc(1, 1, 0); acc(1, 1, 0); acc(1, 1, 1); acc(1, 1, 1);
        acc(1, 2, 1); acc(1, 2, 1); acc(1, 2, 0);
        wr(4, 1);
        acc(4, 2, 1); acc(4, 2, 1); acc(4, 1, 1); acc(4, 1, 1); acc(4, 1, 1);
        wr(0, 7); wr(2, 5);
        acc(2, 3, 0); acc(2, 3, 0); acc(2, 0, 0);

        // R8: zero size turns circular mode off for the group
        cur_req = "R8";
        wr(21, 0);
        wr(6, 16'hFFFF);
        acc(6, 1, 0); acc(6, 1, 1); acc(7, 2, 0); acc(5, 0, 0);
        wr(21, 6);

        // R9: write and update to the same pointer in one cycle
        cur_req = "R9";
        @(posedge clk); #2;
        acc_en = 1'b1; acc_sel = 3'd2; acc_mode = 2'd1; acc_wide = 1'b0;
        cfg_we = 1'b1; cfg_addr = 5'd2; cfg_wdata = 16'h0003;
        @(posedge clk); #2;
        acc_en = 1'b1; acc_sel = 3'd1; acc_mode = 2'd2; acc_wide = 1'b1;
        cfg_we = 1'b1; cfg_addr = 5'd3; cfg_wdata = 16'h0009;
        rd(2); rd(3); acc(2, 0, 0); acc(3, 0, 0);

        // mixed traffic in all modes
        cur_req = "R7";
        for (int k = 0; k < 3000; k++) begin
            @(posedge clk); #2;
            acc_en    = 1'($urandom_range(0, 3) != 0);
            acc_sel   = 3'($urandom);
            acc_mode  = 2'($urandom);
            acc_wide  = 1'($urandom);
            cfg_we    = 1'($urandom_range(0, 9) == 0);
            cfg_addr  = 5'($urandom_range(0, 23));
            cfg_wdata = (cfg_addr < 8) ? 16'($urandom_range(0, 12)) : 16'($urandom);
        end
        @(posedge clk); #2; acc_en = 1'b0; cfg_we = 1'b0;
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule